// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block lets synchronous logic use an external asynchronous static RAM of 512K bytes (19 address bits, 8 data bits). A user request carries a read/write flag, an address and write data. It is taken when `req_valid` and `req_ready` are both high. The controller then drives the address, the active-low chip-select, write-strobe and output-enable lines, and the split data bus (out, in, output-enable). It holds each phase for a whole number of system-clock cycles. Each of these counts is a parameter, rounded up from the memory's nanosecond minimums at the system clock period. The defaults suit a 10 ns part on a 100 MHz clock.

A read returns the sampled byte on `rd_data` together with a one-cycle `rd_valid` pulse. Every strobe, the address and the data-drive enable come straight from flops, so none of them glitches. The controller enables its own data drivers only while the write strobe is low and output-enable is high. When a write follows a read, it inserts dead cycles so that the memory's outputs have turned off before the controller drives the bus.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the operation ends.
- R3: Read phases. For ADDR_SETUP_CYC cycles the address is driven while chip-select, output-enable and write strobe stay high. For the next RD_WAIT_CYC cycles chip-select and output-enable are low and the write strobe is high.
- R4: `rd_data` takes the value on `sram_dq_in` in the last read-wait cycle. `rd_valid` is 1 for exactly one cycle, in the cycle that follows it. `rd_data` keeps its value until the next read completes.
- R5: Write phases. For ADDR_SETUP_CYC cycles chip-select is low and the write strobe is high. For the next WR_PULSE_CYC cycles the write strobe is low and the write data is driven. For the next WR_RECOVER_CYC cycles all strobes are high and the bus is released. Output-enable stays high throughout.
- R6: `sram_dq_oe` is 1 only while `sram_we_n` is 0 and `sram_oe_n` is 1. `sram_we_n` and `sram_oe_n` are never 0 in the same cycle.
- R7: The address does not change while chip-select stays low.
- R8: A write taken directly after a read is preceded by TURN_CYC cycles with all strobes high and the bus released. A write that follows a write, or the first operation after reset, has none.
- R9: `req_ready` returns to 1 after ADDR_SETUP_CYC+RD_WAIT_CYC+1 cycles for a read. For a write it returns after ADDR_SETUP_CYC+WR_PULSE_CYC+WR_RECOVER_CYC cycles, plus TURN_CYC when R8 applies.
- R10: `req_valid` pulses while `req_ready` is 0 are ignored. They start no strobe activity, produce no `rd_valid` and change no memory contents.
- R11: Data written to any address, including 0 and 19'h7FFFF, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 19 | Memory address |
| sram_dq_out | output | 8 | Data driven to memory |
| sram_dq_oe | output | 1 | Data driver enable |
| sram_dq_in | input | 8 | Data returned by memory |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
Every result is tied to the edge that accepts the request; call it cycle 0. For a read, the setup phase fills cycles 1 to ADDR_SETUP_CYC and the strobe-low phase fills the next RD_WAIT_CYC cycles. `rd_valid` follows in cycle ADDR_SETUP_CYC+RD_WAIT_CYC+1, and `req_ready` returns one cycle later. A write is laid out the same way, with an optional turnaround window first, and `req_ready` returns in the cycle after the recovery phase. The bench drives inputs and samples outputs on falling edges. It indexes each sample by its cycle number after the accepting edge and compares it with the phase expected in that cycle. It runs with unequal phase lengths, so an off-by-one in any phase is visible.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // A running phase shortens by exactly one cycle per clock (R9)
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_dq_capture.sv
module sram_dq_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grab,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = grab;
        if (grab) cap_d.data = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    // Completion is a single-cycle pulse (R4)
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // Held data only moves on a completion (R4)
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_strobe_pkg::*;
#(
    parameter int ADDR_W         = 19,
    parameter int DATA_W         = 8,
    parameter int ADDR_SETUP_CYC = 1,
    parameter int RD_WAIT_CYC    = 1,
    parameter int WR_PULSE_CYC   = 1,
    parameter int WR_RECOVER_CYC = 1,
    parameter int TURN_CYC       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n
);

    localparam int MAX_A   = (ADDR_SETUP_CYC > RD_WAIT_CYC) ? ADDR_SETUP_CYC : RD_WAIT_CYC;
    localparam int MAX_B   = (WR_PULSE_CYC > WR_RECOVER_CYC) ? WR_PULSE_CYC : WR_RECOVER_CYC;
    localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_AB > TURN_CYC) ? MAX_AB : TURN_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(ADDR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RDW   = CNT_W'(RD_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(WR_PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(WR_RECOVER_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              last_rd;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{state: ST_IDLE, addr: '0, wdata: '0, ce_n: 1'b1,
                                   we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, last_rd: 1'b0};

    ctrl_t            ctrl_d, ctrl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             grab;

    always_comb begin
        ctrl_d   = ctrl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        grab     = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctrl_d.addr  = req_addr;
                    ctrl_d.wdata = req_wdata;
                    tmr_load     = 1'b1;
                    if (!req_write) begin
                        ctrl_d.state = ST_RD_SETUP;
                        tmr_val      = LD_SETUP;
                    end else if (ctrl_q.last_rd) begin
                        ctrl_d.state = ST_TURNAROUND;
                        tmr_val      = LD_TURN;
                    end else begin
                        ctrl_d.state = ST_WR_SETUP;
                        ctrl_d.ce_n  = 1'b0;
                        tmr_val      = LD_SETUP;
                    end
                end
            end
            ST_RD_SETUP: begin
                if (tmr_done) begin
                    ctrl_d.state = ST_RD_WAIT;
                    ctrl_d.ce_n  = 1'b0;
                    ctrl_d.oe_n  = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_RDW;
                end
            end
            ST_RD_WAIT: begin
                if (tmr_done) begin
                    grab           = 1'b1;
                    ctrl_d.state   = ST_RD_CAPTURE;
                    ctrl_d.ce_n    = 1'b1;
                    ctrl_d.oe_n    = 1'b1;
                    ctrl_d.last_rd = 1'b1;
                end
            end
            ST_RD_CAPTURE: begin
                ctrl_d.state = ST_IDLE;
            end
            ST_TURNAROUND: begin
                if (tmr_done) begin
                    ctrl_d.state = ST_WR_SETUP;
                    ctrl_d.ce_n  = 1'b0;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_SETUP;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_done) begin
                    ctrl_d.state = ST_WR_PULSE;
                    ctrl_d.we_n  = 1'b0;
                    ctrl_d.dq_oe = 1'b1;
                    tmr_load     = 1'b1;
                    tmr_val      = LD_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    ctrl_d.state   = ST_WR_RECOVER;
                    ctrl_d.we_n    = 1'b1;
                    ctrl_d.dq_oe   = 1'b0;
                    ctrl_d.ce_n    = 1'b1;
                    ctrl_d.last_rd = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = LD_REC;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_done) ctrl_d.state = ST_IDLE;
            end
            default: ctrl_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_dq_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .grab     (grab),
        .dq_in    (sram_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign req_ready   = (ctrl_q.state == ST_IDLE);
    assign sram_addr   = ctrl_q.addr;
    assign sram_dq_out = ctrl_q.wdata;
    assign sram_dq_oe  = ctrl_q.dq_oe;
    assign sram_ce_n   = ctrl_q.ce_n;
    assign sram_we_n   = ctrl_q.we_n;
    assign sram_oe_n   = ctrl_q.oe_n;

    // Drivers on only inside a write pulse with memory outputs off (R6)
    assert_bus_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n));

    // Read enable and write strobe never overlap (R6)
    assert_oe_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n));

    // Address frozen while the chip stays selected (R7)
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // Write strobe falls only after chip select has already been low (R5)
    assert_we_after_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_ce_n));

    // Idle controller leaves the memory deselected (R2)
    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

    // A completion pulse is followed by a return to idle (R9)
    assert_ready_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> req_ready);

endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;

    localparam int S  = 2;
    localparam int RW = 3;
    localparam int P  = 2;
    localparam int RC = 1;
    localparam int T  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_in = 8'h5A;
    logic        sram_ce_n, sram_we_n, sram_oe_n;

    int checks = 0;
    int fails  = 0;
    bit last_rd = 1'b0;
    logic [7:0] mem [logic [18:0]];
    logic [7:0] sb  [logic [18:0]];

    always #10 clk = ~clk;

    sram_strobe_ctrl #(
        .ADDR_SETUP_CYC(S), .RD_WAIT_CYC(RW), .WR_PULSE_CYC(P),
        .WR_RECOVER_CYC(RC), .TURN_CYC(T)
    ) i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory: stores during the strobe overlap, answers after half a cycle
    always @(posedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr] = sram_dq_out;
    end
    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            sram_dq_in = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
        else
            sram_dq_in = 8'h5A;
    end

    // Pulse width, bus ownership and address stability monitors
    int we_len = 0;
    int drive_bad = 0;
    int addr_bad = 0;
    bit prev_sel = 1'b0;
    logic [18:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_we_n) we_len++;
            else if (we_len != 0) begin
                check(we_len == P, "R5", "write pulse width", we_len, P);
                we_len = 0;
            end
            if (sram_dq_oe && (sram_we_n || !sram_oe_n)) drive_bad++;
            if (!sram_we_n && !sram_oe_n) drive_bad++;
            if (prev_sel && !sram_ce_n && sram_addr != prev_addr) addr_bad++;
            prev_sel  = !sram_ce_n;
            prev_addr = sram_addr;
        end
    end

    task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          input bit poke, input bit pk_wr, input logic [18:0] pk_a,
                          input logic [7:0] pk_d);
        int turn = (wr && last_rd) ? T : 0;
        int total = wr ? (turn + S + P + RC) : (S + RW + 1);
        int b_turn = 0, b_setup = 0, b_act = 0, b_tail = 0, b_busy = 0;
        logic [7:0] exp = sb.exists(a) ? sb[a] : 8'h00;
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1; req_write = pk_wr; req_addr = pk_a; req_wdata = pk_d;
            end
            if (poke && k == 3) req_valid = 1'b0;
            if (req_ready) b_busy++;
            if (wr) begin
                if (k <= turn) begin
                    if (!(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)) b_turn++;
                end else if (k <= turn + S) begin
                    if (!(!sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && sram_addr == a)) b_setup++;
                end else if (k <= turn + S + P) begin
                    if (!(!sram_ce_n && !sram_we_n && sram_oe_n && sram_dq_oe &&
                          sram_dq_out == d && sram_addr == a)) b_act++;
                end else begin
                    if (!(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)) b_tail++;
                end
            end else begin
                if (k <= S) begin
                    if (!(sram_ce_n && sram_we_n && sram_oe_n && sram_addr == a && !rd_valid)) b_setup++;
                end else if (k <= S + RW) begin
                    if (!(!sram_ce_n && !sram_oe_n && sram_we_n && !sram_dq_oe &&
                          sram_addr == a && !rd_valid)) b_act++;
                end else begin
                    check(rd_valid == 1'b1, "R4", "valid pulse cycle", rd_valid, 1);
                    check(rd_data == exp, "R4", "read data", rd_data, exp);
                    if (!sram_ce_n) b_tail++;
                end
            end
        end
        check(b_busy == 0, "R2", "ready during operation", b_busy, 0);
        if (wr) begin
            check(b_turn == 0, "R8", "turnaround window", b_turn, 0);
            check(b_setup == 0, "R5", "write setup phase", b_setup, 0);
            check(b_act == 0, "R5", "write pulse phase", b_act, 0);
            check(b_tail == 0, "R5", "write recovery phase", b_tail, 0);
        end else begin
            check(b_setup == 0, "R3", "read setup phase", b_setup, 0);
            check(b_act == 0, "R3", "read strobe phase", b_act, 0);
            check(b_tail == 0, "R3", "strobes released at completion", b_tail, 0);
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready returns on time", req_ready, 1);
        check(rd_valid == 1'b0, "R4", "valid drops after one cycle", rd_valid, 0);
        if (wr) sb[a] = d;
        last_rd = !wr;
    endtask

    task automatic t_reset;
        check(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes high in reset",
              {sram_ce_n, sram_we_n, sram_oe_n}, 7);
        check(!sram_dq_oe && !rd_valid, "R1", "bus and valid low", {sram_dq_oe, rd_valid}, 0);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_extremes;
        run_op(1'b1, 19'h00000, 8'h3C, 1'b0, 1'b0, '0, '0);
        run_op(1'b1, 19'h7FFFF, 8'hC3, 1'b0, 1'b0, '0, '0);
        run_op(1'b0, 19'h00000, '0, 1'b0, 1'b0, '0, '0);
        check(rd_data == 8'h3C, "R11", "low address round trip", rd_data, 8'h3C);
        run_op(1'b0, 19'h7FFFF, '0, 1'b0, 1'b0, '0, '0);
        check(rd_data == 8'hC3, "R11", "high address round trip", rd_data, 8'hC3);
    endtask

    task automatic t_turnaround;
        logic [7:0] held;
        run_op(1'b0, 19'h00000, '0, 1'b0, 1'b0, '0, '0);
        held = rd_data;
        run_op(1'b1, 19'h12345, 8'h77, 1'b0, 1'b0, '0, '0);  // read then write: R8 window
        check(rd_data == held, "R4", "read data held across write", rd_data, held);
        run_op(1'b1, 19'h12346, 8'h78, 1'b0, 1'b0, '0, '0);  // write then write: no window
        run_op(1'b0, 19'h12345, '0, 1'b0, 1'b0, '0, '0);
        check(rd_data == 8'h77, "R8", "write after read lands", rd_data, 8'h77);
    endtask

    task automatic t_busy_ignore;
        int act = 0;
        run_op(1'b1, 19'h00ABC, 8'h11, 1'b1, 1'b1, 19'h00ABD, 8'hEE);  // poke: write R10
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!sram_ce_n || rd_valid) act++;
        end
        check(act == 0, "R10", "no activity from ignored request", act, 0);
        run_op(1'b0, 19'h00ABD, '0, 1'b1, 1'b0, 19'h00ABC, 8'h00);     // poke: read R10
        check(rd_data == 8'h00, "R10", "ignored write left memory", rd_data, 8'h00);
        act = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!sram_ce_n || rd_valid) act++;
        end
        check(act == 0, "R10", "no read from ignored request", act, 0);
    endtask

    task automatic t_random;
        logic [18:0] adrs [12];
        for (int i = 0; i < 12; i++) begin
            adrs[i] = 19'($urandom);
            run_op(1'b1, adrs[i], 8'($urandom), 1'b0, 1'b0, '0, '0);
        end
        for (int i = 11; i >= 0; i--) begin
            run_op(1'b0, adrs[i], '0, 1'b0, 1'b0, '0, '0);  // R11 scoreboard compare inside
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_extremes;
        t_turnaround;
        t_busy_ignore;
        t_random;
        check(drive_bad == 0, "R6", "bus ownership violations", drive_bad, 0);
        check(addr_bad == 0, "R7", "address moved while selected", addr_bad, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule